// File: doc/BRIEF.md
# Receive Packet Filter Engine

This block sits behind the byte synchroniser of a sub-GHz receiver. Once the synchroniser reports a found sync word, the engine takes the bytes that follow, works out where the packet ends, and decides whether the packet may stay. A packet may end after a programmed byte count, after a count carried in its first byte, or not at all. It can be dropped because of its length field or its address byte, and its CRC-16 is checked. Accepted bytes go to an external receive FIFO through a single write port. The engine can add two status bytes after the payload. If the CRC fails it can flush the whole FIFO.

Received bytes arrive one at a time with a valid strobe. The byte rate is far below the clock rate, so two valid strobes are always separated by at least one idle cycle. A rejected packet ends with a one-cycle restart pulse, which tells the receiver to hunt for the next sync word. A packet that completes ends with a one-cycle done pulse and a CRC verdict that stays valid until the next packet starts. The configuration inputs must stay stable while a packet is in progress.

Top module: `rx_pkt_filter`

## Requirements
- R1: While reset is active and after it is released, `fifo_wr`, `fifo_flush`, `rx_restart`, `pkt_done` and `crc_ok` are low.
- R2: With `cfg_len_mode` = 0 (fixed length), the first `cfg_pkt_len` bytes after sync are written to the FIFO in arrival order. An address byte, if present, is among them. When the CRC is enabled, the next two bytes are the CRC, high byte first, and they are not written.
- R3: With `cfg_len_mode` = 1 (variable length), the first byte after sync is a length value L that counts the bytes after it, not counting the CRC. The length byte and the following L bytes are written to the FIFO.
- R4: In variable mode, a length byte greater than `cfg_pkt_len` produces a `rx_restart` pulse in the cycle after that byte. Nothing from that packet is written, and no `pkt_done` follows.
- R5: With `cfg_addr_chk` high, the address byte is the first byte after sync in fixed and infinite mode, and the first byte after the length byte in variable mode when L ≥ 1. If it differs from `cfg_dev_addr`, a `rx_restart` pulse follows and nothing from the packet is written, including a held length byte. If it matches, the length byte is written first and the address byte one cycle later.
- R6: With `cfg_len_mode` = 2 or 3 (infinite), every byte is written until `rx_stop`. Bytes after the stop cause no write, and no `pkt_done` is produced.
- R7: The CRC uses x^16+x^15+x^2+1 with preset 0xFFFF, processed MSB first. It covers every byte after sync up to and including the received CRC. `crc_ok` goes high with `pkt_done` when the remainder is zero, and it holds its value until the next accepted sync. With `cfg_crc_en` low there are no CRC bytes and `crc_ok` reads low.
- R8: With `cfg_autoflush` and the CRC enabled, a failed check raises `fifo_flush` for one cycle together with `pkt_done`. No status bytes are written after the flush.
- R9: With `cfg_append` high and no flush, two more bytes are written after the payload: `rssi_in` first, then a byte holding `crc_ok` in bit 7 and `lqi_in` in bits 6..0.
- R10: `pkt_done` is a one-cycle pulse in the cycle after the final byte of the packet is sampled. For a fixed packet of zero length without CRC, the final byte is the sync pulse itself.
- R11: A `sync_found` pulse that arrives while a packet is in progress is ignored, and the packet completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_found | input | 1 | One-cycle pulse: sync word detected |
| rx_stop | input | 1 | Abandons reception and returns to idle |
| in_valid | input | 1 | `in_byte` holds a received byte |
| in_byte | input | 8 | Received byte |
| cfg_len_mode | input | 2 | 0 fixed, 1 variable, 2/3 infinite |
| cfg_pkt_len | input | 8 | Fixed length, or largest allowed length value |
| cfg_addr_chk | input | 1 | Enable address filtering |
| cfg_dev_addr | input | 8 | Address to match |
| cfg_crc_en | input | 1 | Packet carries and checks a CRC-16 |
| cfg_autoflush | input | 1 | Flush the FIFO on CRC failure |
| cfg_append | input | 1 | Append the two status bytes |
| rssi_in | input | 8 | Signal strength for the first status byte |
| lqi_in | input | 7 | Link quality for the second status byte |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_flush | output | 1 | Empty the whole FIFO |
| rx_restart | output | 1 | Packet rejected, restart receive |
| pkt_done | output | 1 | Packet completed |
| crc_ok | output | 1 | CRC verdict of the last completed packet |

## Verification
Every result is registered once. The restart pulse, the done pulse, the flush and the write of an ordinary byte all appear in the cycle after the edge that sampled the byte or sync pulse that caused them. A held length byte comes out in the cycle after the address byte. The address byte and the two status bytes come out one, two and three cycles later, depending on whether a held byte is still waiting. The bench drives inputs on falling edges and records the cycle number of each done and restart pulse on the falling edge. It then compares that number with the cycle of the last driven byte plus one. Write contents are compared as an ordered list after the packet has settled, so they do not depend on the exact cycle of each write.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

  localparam int BYTE_W = 8;
  localparam int LQI_W  = BYTE_W - 1;
  localparam int CRC_W  = 16;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [1:0] LM_FIXED = 2'd0;
  localparam logic [1:0] LM_VAR   = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEN,
    S_BODY,
    S_CRC_HI,
    S_CRC_LO,
    S_TAIL_A,
    S_TAIL_B
  } seq_state_e;

  // One byte of a CRC fed most significant bit first, no reflection.
  function automatic logic [CRC_W-1:0] crc_byte_step(
    input logic [CRC_W-1:0] crc_in,
    input byte_t            data,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] r;
    logic             fb;
    r = crc_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ data[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxpf_crc16.sv
module rxpf_crc16
  import rxpf_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h8005,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  init,
  input  logic  upd,
  input  byte_t din,
  output logic  res_zero
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nx;

  always_comb begin
    crc_nx   = crc_byte_step(crc_q, din, POLY);
    res_zero = (crc_nx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= INIT;
    else if (init) crc_q <= INIT;
    else if (upd)  crc_q <= crc_nx;
  end

endmodule

// File: rtl/rxpf_writer.sv
module rxpf_writer
  import rxpf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_vld,
  input  byte_t a_data,
  input  logic  b_vld,
  input  byte_t b_data,
  output logic  fifo_wr,
  output byte_t fifo_wdata,
  output logic  pend_busy
);

  byte_t pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      pend_busy  <= 1'b0;
      pend_q     <= '0;
    end else begin
      fifo_wr <= 1'b0;
      if (a_vld) begin
        fifo_wr    <= 1'b1;
        fifo_wdata <= a_data;
        pend_busy  <= b_vld;
        pend_q     <= b_data;
      end else if (pend_busy) begin
        fifo_wr    <= 1'b1;
        fifo_wdata <= pend_q;
        pend_busy  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxpf_seq.sv
module rxpf_seq
  import rxpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_found,
  input  logic             rx_stop,
  input  logic             in_valid,
  input  byte_t            in_byte,
  input  logic [1:0]       cfg_len_mode,
  input  byte_t            cfg_pkt_len,
  input  logic             cfg_addr_chk,
  input  byte_t            cfg_dev_addr,
  input  logic             cfg_crc_en,
  input  logic             cfg_autoflush,
  input  logic             cfg_append,
  input  byte_t            rssi_in,
  input  logic [LQI_W-1:0] lqi_in,
  input  logic             crc_zero,
  input  logic             pend_busy,
  output logic             crc_init,
  output logic             crc_upd,
  output logic             a_vld,
  output byte_t            a_data,
  output logic             b_vld,
  output byte_t            b_data,
  output logic             rx_restart,
  output logic             pkt_done,
  output logic             fifo_flush,
  output logic             crc_ok,
  output logic             sync_go
);

  seq_state_e state_q, state_nx;
  byte_t      rem_q, len_q;
  logic       addr_due_q, len_held_q, inf_q;

  logic take, len_bad, is_addr, addr_bad, reject, hold_len;
  logic body_last, len_zero, fix_zero;
  logic fin_now, fin_ok, fin_flush;
  seq_state_e fin_dest;

  always_comb begin
    take      = in_valid && (state_q == S_LEN || state_q == S_BODY ||
                             state_q == S_CRC_HI || state_q == S_CRC_LO);
    sync_go   = sync_found && (state_q == S_IDLE) && !rx_stop;
    len_bad   = take && (state_q == S_LEN) && (in_byte > cfg_pkt_len);
    is_addr   = take && (state_q == S_BODY) && addr_due_q;
    addr_bad  = is_addr && (in_byte != cfg_dev_addr);
    reject    = len_bad || addr_bad;
    hold_len  = cfg_addr_chk && (in_byte != '0);
    body_last = take && (state_q == S_BODY) && !inf_q && !addr_bad &&
                (rem_q == byte_t'(1));
    len_zero  = take && (state_q == S_LEN) && !len_bad && (in_byte == '0);
    fix_zero  = sync_go && (cfg_len_mode == LM_FIXED) && (cfg_pkt_len == '0);

    fin_now   = ((body_last || len_zero || fix_zero) && !cfg_crc_en) ||
                (take && state_q == S_CRC_LO);
    fin_ok    = (state_q == S_CRC_LO) && crc_zero;
    fin_flush = fin_now && cfg_crc_en && cfg_autoflush && !fin_ok;
    fin_dest  = (cfg_append && !fin_flush) ? S_TAIL_A : S_IDLE;

    crc_init  = sync_go;
    crc_upd   = take && !reject;

    a_vld  = 1'b0;
    a_data = in_byte;
    b_vld  = 1'b0;
    b_data = in_byte;
    if (take && state_q == S_LEN && !len_bad && !hold_len) begin
      a_vld = 1'b1;
    end
    if (take && state_q == S_BODY && !addr_bad) begin
      a_vld = 1'b1;
      if (is_addr && len_held_q) begin
        a_data = len_q;
        b_vld  = 1'b1;
      end
    end
    if (state_q == S_TAIL_A && !pend_busy) begin
      a_vld  = 1'b1;
      a_data = rssi_in;
    end
    if (state_q == S_TAIL_B) begin
      a_vld  = 1'b1;
      a_data = {crc_ok, lqi_in};
    end

    state_nx = state_q;
    unique case (state_q)
      S_IDLE: if (sync_go) begin
        if (cfg_len_mode == LM_VAR)        state_nx = S_LEN;
        else if (cfg_len_mode == LM_FIXED) state_nx = (cfg_pkt_len == '0) ? S_CRC_HI : S_BODY;
        else                               state_nx = S_BODY;
      end
      S_LEN:    if (take) state_nx = len_zero ? S_CRC_HI : S_BODY;
      S_BODY:   if (body_last) state_nx = S_CRC_HI;
      S_CRC_HI: if (take) state_nx = S_CRC_LO;
      S_CRC_LO: state_nx = S_CRC_LO;
      S_TAIL_A: if (!pend_busy) state_nx = S_TAIL_B;
      S_TAIL_B: state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
    if (fin_now) state_nx = fin_dest;
    if (reject)  state_nx = S_IDLE;
    if (rx_stop) state_nx = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      rem_q      <= '0;
      len_q      <= '0;
      addr_due_q <= 1'b0;
      len_held_q <= 1'b0;
      inf_q      <= 1'b0;
      rx_restart <= 1'b0;
      pkt_done   <= 1'b0;
      fifo_flush <= 1'b0;
      crc_ok     <= 1'b0;
    end else begin
      state_q    <= state_nx;
      rx_restart <= reject;
      pkt_done   <= fin_now;
      fifo_flush <= fin_flush;
      if (sync_go) begin
        crc_ok     <= 1'b0;
        rem_q      <= cfg_pkt_len;
        addr_due_q <= cfg_addr_chk && (cfg_len_mode != LM_VAR);
        inf_q      <= cfg_len_mode[1];
        len_held_q <= 1'b0;
      end
      if (fin_now) crc_ok <= fin_ok;
      if (take && state_q == S_LEN && !len_bad) begin
        rem_q      <= in_byte;
        len_q      <= in_byte;
        addr_due_q <= hold_len;
        len_held_q <= hold_len;
      end
      if (take && state_q == S_BODY && !addr_bad) begin
        addr_due_q <= 1'b0;
        len_held_q <= 1'b0;
        if (!inf_q) rem_q <= rem_q - byte_t'(1);
      end
    end
  end

endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter
  import rxpf_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'h8005,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_found,
  input  logic       rx_stop,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic [1:0] cfg_len_mode,
  input  logic [7:0] cfg_pkt_len,
  input  logic       cfg_addr_chk,
  input  logic [7:0] cfg_dev_addr,
  input  logic       cfg_crc_en,
  input  logic       cfg_autoflush,
  input  logic       cfg_append,
  input  logic [7:0] rssi_in,
  input  logic [6:0] lqi_in,
  output logic       fifo_wr,
  output logic [7:0] fifo_wdata,
  output logic       fifo_flush,
  output logic       rx_restart,
  output logic       pkt_done,
  output logic       crc_ok
);

  // Named internal events, also observed by the bound checker.
  logic  crc_init, crc_upd, crc_zero;
  logic  wr_a_vld, wr_b_vld, pend_busy, sync_go;
  byte_t wr_a_data, wr_b_data;

  rxpf_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .din(in_byte), .res_zero(crc_zero)
  );

  rxpf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sync_found(sync_found), .rx_stop(rx_stop),
    .in_valid(in_valid), .in_byte(in_byte), .cfg_len_mode(cfg_len_mode),
    .cfg_pkt_len(cfg_pkt_len), .cfg_addr_chk(cfg_addr_chk),
    .cfg_dev_addr(cfg_dev_addr), .cfg_crc_en(cfg_crc_en),
    .cfg_autoflush(cfg_autoflush), .cfg_append(cfg_append),
    .rssi_in(rssi_in), .lqi_in(lqi_in), .crc_zero(crc_zero),
    .pend_busy(pend_busy), .crc_init(crc_init), .crc_upd(crc_upd),
    .a_vld(wr_a_vld), .a_data(wr_a_data), .b_vld(wr_b_vld), .b_data(wr_b_data),
    .rx_restart(rx_restart), .pkt_done(pkt_done), .fifo_flush(fifo_flush),
    .crc_ok(crc_ok), .sync_go(sync_go)
  );

  rxpf_writer u_wr (
    .clk(clk), .rst_n(rst_n), .a_vld(wr_a_vld), .a_data(wr_a_data),
    .b_vld(wr_b_vld), .b_data(wr_b_data), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .pend_busy(pend_busy)
  );

endmodule

// File: rtl/rxpf_checker.sv
module rxpf_checker (
  input logic clk,
  input logic rst_n,
  input logic fifo_wr,
  input logic fifo_flush,
  input logic rx_restart,
  input logic pkt_done,
  input logic crc_ok,
  input logic wr_a_vld,
  input logic pend_busy,
  input logic sync_go
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  assert_done_not_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_done && rx_restart));

  assert_reject_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_restart |-> !fifo_wr);

  assert_single_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_a_vld && pend_busy));

  assert_flush_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (pkt_done && !crc_ok));

  assert_no_status_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_wr);

  assert_crc_ok_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && !$past(sync_go)) |-> $stable(crc_ok));

endmodule

bind rx_pkt_filter rxpf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_flush(fifo_flush),
  .rx_restart(rx_restart), .pkt_done(pkt_done), .crc_ok(crc_ok),
  .wr_a_vld(wr_a_vld), .pend_busy(pend_busy), .sync_go(sync_go)
);

// File: tb/rx_pkt_filter_bench.sv
module rx_pkt_filter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_found = 1'b0, rx_stop = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [1:0] cfg_len_mode = '0;
  logic [7:0] cfg_pkt_len = '0, cfg_dev_addr = '0, rssi_in = '0;
  logic       cfg_addr_chk = 0, cfg_crc_en = 0, cfg_autoflush = 0, cfg_append = 0;
  logic [6:0] lqi_in = '0;
  logic       fifo_wr, fifo_flush, rx_restart, pkt_done, crc_ok;
  logic [7:0] fifo_wdata;

  rx_pkt_filter u_rx_pkt_filter (
    .clk(clk), .rst_n(rst_n), .sync_found(sync_found), .rx_stop(rx_stop),
    .in_valid(in_valid), .in_byte(in_byte), .cfg_len_mode(cfg_len_mode),
    .cfg_pkt_len(cfg_pkt_len), .cfg_addr_chk(cfg_addr_chk),
    .cfg_dev_addr(cfg_dev_addr), .cfg_crc_en(cfg_crc_en),
    .cfg_autoflush(cfg_autoflush), .cfg_append(cfg_append),
    .rssi_in(rssi_in), .lqi_in(lqi_in), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .fifo_flush(fifo_flush),
    .rx_restart(rx_restart), .pkt_done(pkt_done), .crc_ok(crc_ok)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int n_done, n_rst, n_flush, done_cyc, rst_cyc, last_cyc;
  logic [7:0] got[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_flush) begin got.delete(); n_flush++; end
      if (fifo_wr) got.push_back(fifo_wdata);
      if (pkt_done) begin n_done++; done_cyc = cyc; end
      if (rx_restart) begin n_rst++; rst_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_q(input string req, input logic [7:0] e[$]);
    bit same;
    int bad;
    same = (got.size() == e.size());
    bad = -1;
    if (same) for (int i = 0; i < e.size(); i++) if (bad < 0 && got[i] != e[i]) bad = i;
    if (!same) chk(0, req, "fifo byte count", got.size(), e.size());
    else if (bad >= 0) chk(0, req, $sformatf("fifo byte %0d", bad), got[bad], e[bad]);
    else chk(1, req, "fifo", 0, 0);
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] s[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (s[k]) for (int b = 7; b >= 0; b--) begin
      logic t;
      t = c[15] ^ s[k][b];
      c = c << 1;
      if (t) begin c[15] = ~c[15]; c[2] = ~c[2]; c[0] = ~c[0]; end
    end
    return c;
  endfunction

  task automatic clr();
    got.delete(); n_done = 0; n_rst = 0; n_flush = 0; done_cyc = -1; rst_cyc = -1;
  endtask

  task automatic put_byte(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b; last_cyc = cyc;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_sync();
    sync_found = 1'b1; last_cyc = cyc;
    @(negedge clk); sync_found = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_stop();
    rx_stop = 1'b1;
    @(negedge clk); rx_stop = 1'b0;
    @(negedge clk);
  endtask

  // One packet; expected results follow from the requirements.
  task automatic run_pkt(input logic [1:0] mode, input int plen, input int nvar,
                         input bit achk, input bit amatch, input bit crc,
                         input bit corrupt, input bit afl, input bit app);
    logic [7:0] s[$], e[$];
    logic [15:0] c;
    int cnt;
    bit rej_len, rej_adr, good, flush_exp, ok_exp;
    string tag;
    cfg_len_mode = mode; cfg_pkt_len = 8'(plen); cfg_addr_chk = achk;
    cfg_dev_addr = 8'($urandom); cfg_crc_en = crc; cfg_autoflush = afl;
    cfg_append = app; rssi_in = 8'($urandom); lqi_in = 7'($urandom);
    tag = (mode == 2'd1) ? "R3" : "R2";
    cnt = (mode == 2'd1) ? nvar : plen;
    rej_len = (mode == 2'd1) && (nvar > plen);
    rej_adr = !rej_len && achk && cnt > 0 && !amatch;
    if (mode == 2'd1) s.push_back(8'(nvar));
    if (!rej_len) for (int i = 0; i < cnt; i++) begin
      if (i == 0 && achk) s.push_back(amatch ? cfg_dev_addr : cfg_dev_addr ^ 8'h5A);
      else s.push_back(8'($urandom));
      if (rej_adr) break;
    end
    good = !rej_len && !rej_adr;
    e = good ? s : '{};
    ok_exp = good && crc && !corrupt;
    flush_exp = good && crc && afl && corrupt;
    if (good && crc) begin
      c = ref_crc(s);
      s.push_back(c[15:8]);
      s.push_back(c[7:0] ^ {7'd0, corrupt});
    end
    if (flush_exp) e.delete();
    else if (good && app) begin e.push_back(rssi_in); e.push_back({ok_exp, lqi_in}); end
    clr();
    pulse_sync();
    foreach (s[k]) put_byte(s[k]);
    repeat (6) @(negedge clk);
    cmp_q(rej_len ? "R4" : (rej_adr ? "R5" : tag), e);
    chk(n_done == int'(good), "R10", "done count", n_done, int'(good));
    if (good) chk(done_cyc == last_cyc + 1, "R10", "done cycle", done_cyc, last_cyc + 1);
    chk(n_rst == int'(!good), rej_len ? "R4" : "R5", "restart count", n_rst, int'(!good));
    if (!good) chk(rst_cyc == last_cyc + 1, rej_len ? "R4" : "R5", "restart cycle",
                   rst_cyc, last_cyc + 1);
    if (good) chk(crc_ok == ok_exp, "R7", "crc_ok", crc_ok, ok_exp);
    chk(n_flush == int'(flush_exp), "R8", "flush count", n_flush, int'(flush_exp));
    if (good && app && !flush_exp && got.size() >= 2)
      chk(got[got.size()-2] == rssi_in && got[got.size()-1] == {ok_exp, lqi_in},
          "R9", "status bytes", got[got.size()-1], {ok_exp, lqi_in});
  endtask

  task automatic run_inf(input logic [1:0] mode, input bit achk);
    logic [7:0] e[$];
    logic [7:0] b;
    cfg_len_mode = mode; cfg_addr_chk = achk; cfg_dev_addr = 8'h3C;
    cfg_crc_en = 1'b1; cfg_append = 1'b1; cfg_autoflush = 1'b1;
    clr();
    pulse_sync();
    for (int i = 0; i < 5; i++) begin
      b = (i == 0 && achk) ? 8'h3C : 8'($urandom);
      e.push_back(b);
      put_byte(b);
    end
    pulse_stop();
    put_byte(8'hEE); put_byte(8'h11);
    repeat (6) @(negedge clk);
    cmp_q("R6", e);
    chk(n_done == 0, "R6", "done count", n_done, 0);
    chk(n_rst == 0, "R6", "restart count", n_rst, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] e[$];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({fifo_wr, fifo_flush, rx_restart, pkt_done, crc_ok} == 5'b0, "R1",
        "outputs in reset", {fifo_wr, fifo_flush, rx_restart, pkt_done, crc_ok}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({fifo_wr, fifo_flush, rx_restart, pkt_done, crc_ok} == 5'b0, "R1",
        "outputs after reset", {fifo_wr, fifo_flush, rx_restart, pkt_done, crc_ok}, 0);

    // Directed corners.
    run_pkt(2'd0, 4, 0, 0, 1, 1, 0, 0, 1);   // R2 fixed, good CRC, status
    run_pkt(2'd1, 3, 5, 0, 1, 1, 0, 0, 1);   // R4 length above max
    run_pkt(2'd1, 3, 3, 0, 1, 1, 0, 0, 0);   // R4 length equal to max accepted
    run_pkt(2'd1, 6, 4, 1, 0, 1, 0, 0, 1);   // R5 address mismatch
    run_pkt(2'd0, 5, 0, 1, 0, 0, 0, 0, 0);   // R5 fixed-mode mismatch
    run_pkt(2'd1, 6, 1, 1, 1, 0, 0, 0, 1);   // R5 held length, address last, R9
    run_pkt(2'd0, 0, 0, 0, 1, 0, 0, 0, 0);   // R10 empty fixed packet
    run_pkt(2'd1, 4, 0, 1, 1, 1, 0, 0, 1);   // R3 zero length with CRC
    run_pkt(2'd0, 3, 0, 0, 1, 1, 1, 1, 1);   // R8 failed CRC flushes
    run_pkt(2'd1, 7, 5, 1, 1, 1, 1, 0, 1);   // R7 failed CRC kept, crc_ok low
    run_pkt(2'd0, 2, 0, 0, 1, 0, 0, 0, 1);   // R7 CRC off, no CRC bytes
    run_inf(2'd2, 1'b0);                      // R6
    run_inf(2'd3, 1'b1);                      // R6 with address byte

    // R11: a second sync inside a fixed packet is ignored.
    cfg_len_mode = 2'd0; cfg_pkt_len = 8'd3; cfg_addr_chk = 0; cfg_crc_en = 0;
    cfg_append = 0; cfg_autoflush = 0;
    clr();
    pulse_sync();
    put_byte(8'hA1);
    pulse_sync();
    put_byte(8'hB2); put_byte(8'hC3);
    repeat (6) @(negedge clk);
    e = '{8'hA1, 8'hB2, 8'hC3};
    cmp_q("R11", e);
    chk(n_done == 1 && done_cyc == last_cyc + 1, "R11", "done after third byte",
        done_cyc, last_cyc + 1);

    // Random mix.
    for (int p = 0; p < 60; p++) begin
      logic [1:0] m;
      int pl;
      m = 2'($urandom % 2);
      pl = int'($urandom % 8);
      run_pkt(m, pl, int'($urandom % 10), 1'($urandom), ($urandom % 7) != 0,
              1'($urandom), ($urandom % 3) == 0, 1'($urandom), 1'($urandom));
    end

    summary();
    $finish;
  end

endmodule